// File: doc/BRIEF.md
# GMII Receive Byte-to-Word Packer

This block sits right after a byte-wide GMII-style receive port. On every rising edge of the receive clock it samples a data byte, a data-valid strobe and a line-error strobe. It gathers the bytes of each frame into 32-bit words and sends them out on a packet stream that has no ready signal. Each output word carries a valid pulse, start-of-packet and end-of-packet marks, a 2-bit count of the unused byte lanes in the last word, and an error flag.

The data-valid strobe alone defines the frame boundaries. The first sampled cycle with valid high opens a frame. The first sampled cycle with valid low closes it. The block cannot know that a word is the last one until valid drops. For that reason a full word is held back until the next byte arrives, and the final word leaves one cycle after the fall of data valid.

The line error may be high for only a single cycle anywhere in the frame. The block latches it and reports it on that frame's end-of-packet word. The latch is reloaded at the start of each frame.

A small controller with two states moves between frames:
- IDLE: waiting between frames.
- COLLECT: inside a frame.

It raises one of four events:
- START: IDLE to COLLECT, when valid is sampled high.
- APPEND: stay in COLLECT, when valid is high and the word is not full.
- ROLL: stay in COLLECT, when valid is high and the word is full. The held word is sent and a new word begins with this byte.
- FINISH: COLLECT to IDLE, when valid is sampled low. The last word is sent with end-of-packet.

Top module: `gmii_rx_packer`

## Requirements
- R1: While reset is low, and on the first sampled cycle after it is released, out_valid, out_sop, out_eop, out_empty and out_err are all 0.
- R2: The first byte of each output word occupies out_data[31:24], and later bytes fill [23:16], [15:8] and [7:0] in arrival order. Lanes of a final word that hold no byte read as zero.
- R3: out_sop is 1 on the first word of each frame and 0 on every other word of that frame.
- R4: The end-of-packet word appears with out_valid on the output in the cycle after the edge that samples rx_dv low, and out_empty = (4 − bytes in that word) mod 4. Words that are not the last one carry out_empty = 0 and out_eop = 0.
- R5: If rx_er is sampled high on any cycle where rx_dv is high, including a single-cycle pulse, out_err is 1 on that frame's end-of-packet word. out_err is 0 on every word that is not an end-of-packet word.
- R6: The error record is cleared when a new frame starts, so an error never marks a later frame. rx_er while rx_dv is low has no effect.
- R7: out_valid is high for exactly one cycle per word. A full word is sent on the edge that samples the following byte of the same frame. No output is produced on the edge that starts a frame, or while idle.
- R8: A one-byte frame yields one word with out_sop = 1, out_eop = 1 and out_empty = 3.
- R9: A new frame may start after a single idle cycle, and the two frames are still delivered separately and correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received data byte |
| rx_dv | input | 1 | Data valid; high across the whole frame |
| rx_er | input | 1 | Line error strobe |
| out_data | output | 32 | Packed word; first byte in the top lane |
| out_valid | output | 1 | One-cycle pulse per emitted word |
| out_sop | output | 1 | First word of a frame |
| out_eop | output | 1 | Last word of a frame |
| out_empty | output | 2 | Unused lanes in the last word |
| out_err | output | 1 | Frame saw a line error (last word only) |

## Verification
The bench uses the default parameters: 8-bit bytes and four lanes per word. With these values every empty count from 0 to 3 is reached by frame lengths modulo 4. The roll from one word to the next happens every fourth byte, so random frames of 1 to 24 bytes pass through many word boundaries. Directed frames place a single-cycle error pulse on the first byte, on a middle byte and on the last byte. They also send error strobes in idle gaps, one-byte frames, and frames separated by one idle cycle.

// File: rtl/gmii_rx_pkg.sv
`timescale 1ns/1ps
package gmii_rx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } rx_state_e;

    // Event raised by the controller for one sampled cycle
    typedef struct packed {
        logic start;
        logic append;
        logic roll;
        logic finish;
    } rx_evt_t;

endpackage

// File: rtl/gmii_rx_ctrl.sv
`timescale 1ns/1ps
module gmii_rx_ctrl
    import gmii_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    dv,
    input  logic    word_full,
    output rx_evt_t evt
);

    rx_state_e state_q;
    rx_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        evt        = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (dv) begin
                    evt.start = 1'b1;
                    state_d   = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (!dv) begin
                    evt.finish = 1'b1;
                    state_d    = ST_IDLE;
                end else if (word_full) begin
                    evt.roll   = 1'b1;
                end else begin
                    evt.append = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/gmii_rx_lane_buf.sv
`timescale 1ns/1ps
module gmii_rx_lane_buf
    import gmii_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  rx_evt_t           evt,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o
);

    logic [CNT_W-1:0] cnt_q;

    // Byte count of the word being built
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt.start || evt.roll) begin
            cnt_q <= CNT_W'(1);
        end else if (evt.append) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count_o = cnt_q;
    assign full_o  = (cnt_q == CNT_W'(LANES));

    // One register per byte lane; lane 0 is the most significant
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (evt.start || evt.roll) begin
                lane_q <= (g == 0) ? byte_i : '0;
            end else if (evt.append && (cnt_q == CNT_W'(g))) begin
                lane_q <= byte_i;
            end
        end

        assign word_o[WORD_W-1-g*BYTE_W -: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/gmii_rx_err_latch.sv
`timescale 1ns/1ps
module gmii_rx_err_latch
    import gmii_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    er,
    input  rx_evt_t evt,
    output logic    err_o
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (evt.start) begin
            err_q <= er;
        end else if (evt.append || evt.roll) begin
            err_q <= err_q | er;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/gmii_rx_packer.sv
`timescale 1ns/1ps
module gmii_rx_packer
    import gmii_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int WORD_W  = BYTE_W * LANES,
    localparam int CNT_W   = $clog2(LANES + 1),
    localparam int EMPTY_W = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               rx_dv,
    input  logic               rx_er,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_valid,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_err
);

    rx_evt_t           evt;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic              err_seen;
    logic              sop_pend_q;

    gmii_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dv        (rx_dv),
        .word_full (full),
        .evt       (evt)
    );

    gmii_rx_lane_buf #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_i  (rx_byte),
        .evt     (evt),
        .word_o  (word),
        .count_o (count),
        .full_o  (full)
    );

    gmii_rx_err_latch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .er    (rx_er),
        .evt   (evt),
        .err_o (err_seen)
    );

    // Start-of-packet belongs to the first word emitted after START
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sop_pend_q <= 1'b0;
        end else if (evt.start) begin
            sop_pend_q <= 1'b1;
        end else if (evt.roll || evt.finish) begin
            sop_pend_q <= 1'b0;
        end
    end

    // Output word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_empty <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_empty <= '0;
            out_err   <= 1'b0;
            if (evt.roll) begin
                out_data  <= word;
                out_valid <= 1'b1;
                out_sop   <= sop_pend_q;
            end else if (evt.finish) begin
                out_data  <= word;
                out_valid <= 1'b1;
                out_sop   <= sop_pend_q;
                out_eop   <= 1'b1;
                out_empty <= EMPTY_W'(LANES - int'(count));
                out_err   <= err_seen;
            end
        end
    end

endmodule

// File: rtl/gmii_rx_packer_chk.sv
`timescale 1ns/1ps
module gmii_rx_packer_chk #(
    parameter int EMPTY_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_dv,
    input logic               out_valid,
    input logic               out_sop,
    input logic               out_eop,
    input logic [EMPTY_W-1:0] out_empty,
    input logic               out_err
);

    AST_ERR_ON_EOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_eop)); // R5

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sop && !out_eop && out_empty == '0)); // R7

    AST_EOP_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |-> !$past(rx_dv)); // R4

    AST_MIDWORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |-> (out_empty == '0)); // R4

    AST_NO_OUT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |=> !out_valid); // R7

endmodule

bind gmii_rx_packer gmii_rx_packer_chk #(.EMPTY_W(EMPTY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_dv     (rx_dv),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_empty (out_empty),
    .out_err   (out_err)
);

// File: tb/gmii_rx_packer_test.sv
`timescale 1ns/1ps
module gmii_rx_packer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_dv = 1'b0;
    logic        rx_er = 1'b0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_sop;
    logic        out_eop;
    logic [1:0]  out_empty;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    gmii_rx_packer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_byte   (rx_byte),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_empty (out_empty),
        .out_err   (out_err)
    );

    // Reference model state
    bit          m_in_frame = 0;
    int          m_cnt      = 0;
    bit          m_first    = 0;
    bit          m_err      = 0;
    logic [31:0] m_word     = '0;
    logic [7:0]  next_byte  = 8'h01;

    bit          e_valid = 0;
    logic [31:0] e_data  = '0;
    bit          e_sop   = 0;
    bit          e_eop   = 0;
    logic [1:0]  e_empty = '0;
    bit          e_err   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] empty_of(input int nbytes);
        return 2'((4 - nbytes) % 4);
    endfunction

    task automatic compare();
        if (e_valid) begin
            check(out_valid == 1'b1, "R7", "valid", 32'(out_valid), 32'd1);
            check(out_data == e_data, "R2", "data", out_data, e_data);
            check(out_sop == e_sop, "R3", "sop", 32'(out_sop), 32'(e_sop));
            check(out_eop == e_eop, "R4", "eop", 32'(out_eop), 32'(e_eop));
            check(out_empty == e_empty, "R4", "empty", 32'(out_empty), 32'(e_empty));
            check(out_err == e_err, "R5", "err", 32'(out_err), 32'(e_err));
        end else begin
            check(out_valid == 1'b0, "R7", "idle valid", 32'(out_valid), 32'd0);
        end
    endtask

    task automatic model(input bit dv, input logic [7:0] b, input bit er);
        e_valid = 0; e_sop = 0; e_eop = 0; e_empty = '0; e_err = 0;
        if (dv) begin
            if (!m_in_frame) begin
                m_in_frame = 1; m_cnt = 1; m_first = 1; m_err = er;
                m_word = {b, 24'h0};
            end else if (m_cnt == 4) begin
                e_valid = 1; e_data = m_word; e_sop = m_first;
                m_first = 0; m_cnt = 1; m_err = m_err | er;
                m_word = {b, 24'h0};
            end else begin
                m_word[31 - 8*m_cnt -: 8] = b;
                m_cnt++;
                m_err = m_err | er;
            end
        end else if (m_in_frame) begin
            e_valid = 1; e_data = m_word; e_sop = m_first; e_eop = 1;
            e_empty = empty_of(m_cnt); e_err = m_err;
            m_in_frame = 0;
        end
    endtask

    task automatic step(input bit dv, input logic [7:0] b, input bit er);
        @(negedge clk);
        compare();
        model(dv, b, er);
        rx_dv = dv; rx_byte = b; rx_er = er;
    endtask

    // err_pos < 0: no error; gap_er drives rx_er during idle gap (R6)
    task automatic send_frame(input int len, input int err_pos,
                              input int gap, input bit gap_er);
        for (int i = 0; i < len; i++) begin
            step(1'b1, next_byte, (i == err_pos));
            next_byte = next_byte + 8'd1;
        end
        for (int g = 0; g < gap; g++) begin
            step(1'b0, 8'($urandom), gap_er);
        end
    endtask

    initial begin
        void'($urandom(32'd20240617));
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 0 && out_sop == 0 && out_eop == 0 && out_empty == 0 && out_err == 0,
                  "R1", "reset outputs", {27'd0, out_valid, out_sop, out_eop, out_empty}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_err == 0, "R1", "after reset", 32'(out_valid), 32'd0);

        // R8 one-byte frame, then R9 single-gap back-to-back
        send_frame(1, -1, 1, 1'b0);
        send_frame(1, 0, 1, 1'b0);
        send_frame(3, -1, 2, 1'b0);
        // R4 exact word, R2 lane order
        send_frame(4, -1, 2, 1'b0);
        // R5 single-cycle error in the middle, on the first and on the last byte
        send_frame(5, 2, 1, 1'b0);
        send_frame(9, 0, 2, 1'b0);
        send_frame(8, 7, 1, 1'b0);
        // R6 error clears at next frame; rx_er in gap is ignored
        send_frame(6, -1, 3, 1'b1);
        send_frame(2, -1, 1, 1'b1);
        send_frame(7, -1, 1, 1'b0);

        // Constrained random frames (R2..R9)
        for (int f = 0; f < 300; f++) begin
            int len;
            int ep;
            len = 1 + int'($urandom % 24);
            ep  = (($urandom % 4) == 0) ? int'($urandom % len) : -1;
            send_frame(len, ep, 1 + int'($urandom % 4), bit'($urandom % 2));
        end
        repeat (4) step(1'b0, 8'h00, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule